// File: doc/BRIEF.md
# Index-Register Address Generator

This block turns an operand request into an effective memory address. It holds a file of sixteen 32-bit pointer registers and a bank of sixteen 16-bit data registers. Each request names a pointer register and one of five addressing forms. The pointer can be used as it stands, or with a signed 12-bit immediate added, or with a sign-extended data register added. It can also be used first and then stepped up by one or two, or stepped down by one or two and then used. The result is registered and is checked against an inclusive address window. An address inside the window gives a valid strobe. An address outside it gives an illegal-access flag instead.

Software sets up a pointer through a load port before using it. The data registers are written through their own write port. The instruction decoder drives the request inputs, and the memory interface uses the registered address, the strobe and the flag.

Top module: `ixaddr_gen`

## Requirements
- R1: During and right after a synchronous active-low reset, `ea_valid` and `ea_illegal` are low and `ea_addr` is zero. Every pointer register and every data register reads as zero.
- R2: With `req_mode` = 0 (plain), the address is the selected pointer register's value.
- R3: With `req_mode` = 1 (immediate), `req_ofs` is read as 12-bit two's complement, sign-extended and added to the pointer. The pointer is left unchanged.
- R4: With `req_mode` = 2 (register offset), the data register chosen by `req_dsel` is sign-extended from 16 bits and added to the pointer. The pointer is left unchanged. A data register write in the same cycle as such a request is not seen by that request, only by later ones.
- R5: With `req_mode` = 3 (post-step), the address is the pointer's present value. The pointer then grows by 1 when `req_step2` = 0, or by 2 when `req_step2` = 1.
- R6: With `req_mode` = 4 (pre-step), the pointer shrinks by 1 when `req_step2` = 0, or by 2 when `req_step2` = 1. That reduced value is both the address and the new pointer value.
- R7: `ld_en` writes `ld_addr` into pointer `ld_idx`. A request in the next cycle sees the loaded value. If a load and a step write-back target the same pointer in the same cycle, the load wins.
- R8: An address is legal when `ADDR_LO <= addr <= ADDR_HI` (unsigned, inclusive). By default these are 0x10 and 0xFFFF. A legal address raises `ea_valid`. An illegal one raises `ea_illegal` with `ea_valid` low. The two are never high together. The step write-back still happens on an illegal access.
- R9: A request sampled on a clock edge produces its result on the outputs after that edge. The step write-back takes effect on the same edge, so a request issued in the next cycle sees the new pointer. With no request, both strobes are low.
- R10: All address arithmetic wraps modulo 2^32. The unused mode codes 5 to 7 behave as plain mode with no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operand request present |
| req_mode | input | 3 | Addressing form, 0..4 as in the requirements |
| req_idx | input | 4 | Pointer register select |
| req_dsel | input | 4 | Data register select for register-offset mode |
| req_ofs | input | 12 | Signed immediate offset |
| req_step2 | input | 1 | Step size: 0 steps by 1, 1 steps by 2 |
| ld_en | input | 1 | Pointer load strobe |
| ld_idx | input | 4 | Pointer to load |
| ld_addr | input | 32 | Base address to load |
| dw_en | input | 1 | Data register write strobe |
| dw_sel | input | 4 | Data register to write |
| dw_data | input | 16 | Data register write value |
| ea_addr | output | 32 | Effective address, registered |
| ea_valid | output | 1 | Legal access strobe |
| ea_illegal | output | 1 | Out-of-window access flag |

## Verification
A wrong pointer value has no output of its own. It only shows in `ea_addr` on the next request that selects that register, so the bench reads pointers back with plain requests right after each load, step and illegal access. A write-back that is lost or misdirected shows up on a later random request to that register, possibly many cycles later. A wrong bounds decision or a wrong result latency is visible in the very next cycle on `ea_valid` and `ea_illegal`.

// File: rtl/ixaddr_pkg.sv
// Shared encodings for the index-register address generator.
// Assumes the mode field is three bits wide; codes above 4 are unused.
package ixaddr_pkg;
    typedef enum logic [2:0] {
        AM_PLAIN   = 3'd0,
        AM_CONST   = 3'd1,
        AM_DREG    = 3'd2,
        AM_POSTINC = 3'd3,
        AM_PREDEC  = 3'd4
    } amode_e;
endpackage

// File: rtl/ixaddr_regbank.sv
// Register bank with two write ports and one combinational read port.
// The "hi" port has priority over the "lo" port when both hit the same
// entry. Assumes N is a power of two. Reset clears every entry.
module ixaddr_regbank #(
    parameter int N = 16,
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hi_en,
    input  logic [$clog2(N)-1:0] hi_sel,
    input  logic [W-1:0]         hi_data,
    input  logic                 lo_en,
    input  logic [$clog2(N)-1:0] lo_sel,
    input  logic [W-1:0]         lo_data,
    input  logic [$clog2(N)-1:0] rd_sel,
    output logic [W-1:0]         rd_data
);
    localparam int SW = $clog2(N);

    logic [W-1:0] mem [N];

    // Per-entry update: the priority port is checked first.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (hi_en && hi_sel == SW'(i))
                mem[i] <= hi_data;
            else if (lo_en && lo_sel == SW'(i))
                mem[i] <= lo_data;
        end
    end

    // Read port: the value as it stands before this clock edge.
    assign rd_data = mem[rd_sel];
endmodule

// File: rtl/ixaddr_calc.sv
// Combinational address arithmetic and window check for one request.
// Produces the effective address, the pointer write-back value, and
// whether that address lies inside [LO, HI]. Assumes AW > OW and AW > DW.
module ixaddr_calc
    import ixaddr_pkg::*;
#(
    parameter int             AW = 32,
    parameter int             DW = 16,
    parameter int             OW = 12,
    parameter logic [AW-1:0]  LO = 'h10,
    parameter logic [AW-1:0]  HI = 'hFFFF
) (
    input  logic [2:0]    mode,
    input  logic          step2,
    input  logic [AW-1:0] ix_val,
    input  logic [DW-1:0] dr_val,
    input  logic [OW-1:0] ofs,
    output logic [AW-1:0] ea,
    output logic          wb_en,
    output logic [AW-1:0] wb_val,
    output logic          in_range
);
    logic [AW-1:0] ofs_ext;
    logic [AW-1:0] dr_ext;
    logic [AW-1:0] step;

    // Operand extension and step size selection.
    assign ofs_ext = {{(AW-OW){ofs[OW-1]}}, ofs};
    assign dr_ext  = {{(AW-DW){dr_val[DW-1]}}, dr_val};
    assign step    = step2 ? AW'(2) : AW'(1);

    // Mode dispatch: address and write-back for each addressing form.
    always_comb begin
        ea     = ix_val;
        wb_en  = 1'b0;
        wb_val = ix_val;
        case (mode)
            AM_CONST:   ea = ix_val + ofs_ext;
            AM_DREG:    ea = ix_val + dr_ext;
            AM_POSTINC: begin
                wb_en  = 1'b1;
                wb_val = ix_val + step;
            end
            AM_PREDEC: begin
                wb_en  = 1'b1;
                wb_val = ix_val - step;
                ea     = ix_val - step;
            end
            default:    ea = ix_val;
        endcase
    end

    // Inclusive window check on the effective address.
    assign in_range = (ea >= LO) && (ea <= HI);
endmodule

// File: rtl/ixaddr_gen.sv
// Index-register indirect address generator (top).
// Holds the pointer and data register banks, computes one effective
// address per request and registers it with a valid or illegal flag.
// Assumes loads and data writes are single-cycle strobes; a request
// reads register contents from before the current clock edge.
module ixaddr_gen #(
    parameter int            IDX_N   = 16,
    parameter int            DREG_N  = 16,
    parameter int            AW      = 32,
    parameter int            DW      = 16,
    parameter int            OW      = 12,
    parameter logic [AW-1:0] ADDR_LO = 'h10,
    parameter logic [AW-1:0] ADDR_HI = 'hFFFF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [2:0]                req_mode,
    input  logic [$clog2(IDX_N)-1:0]  req_idx,
    input  logic [$clog2(DREG_N)-1:0] req_dsel,
    input  logic [OW-1:0]             req_ofs,
    input  logic                      req_step2,
    input  logic                      ld_en,
    input  logic [$clog2(IDX_N)-1:0]  ld_idx,
    input  logic [AW-1:0]             ld_addr,
    input  logic                      dw_en,
    input  logic [$clog2(DREG_N)-1:0] dw_sel,
    input  logic [DW-1:0]             dw_data,
    output logic [AW-1:0]             ea_addr,
    output logic                      ea_valid,
    output logic                      ea_illegal
);
    localparam int DSW = $clog2(DREG_N);

    logic [AW-1:0] ix_val;
    logic [DW-1:0] dr_val;
    logic [AW-1:0] ea_nxt;
    logic [AW-1:0] wb_val;
    logic          wb_en;
    logic          in_range;

    // Pointer bank: explicit load outranks the step write-back.
    ixaddr_regbank #(.N(IDX_N), .W(AW)) u_ixbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_en   (ld_en),
        .hi_sel  (ld_idx),
        .hi_data (ld_addr),
        .lo_en   (req_valid && wb_en),
        .lo_sel  (req_idx),
        .lo_data (wb_val),
        .rd_sel  (req_idx),
        .rd_data (ix_val)
    );

    // Data register bank: one write port, second port unused.
    ixaddr_regbank #(.N(DREG_N), .W(DW)) u_drbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_en   (dw_en),
        .hi_sel  (dw_sel),
        .hi_data (dw_data),
        .lo_en   (1'b0),
        .lo_sel  ({DSW{1'b0}}),
        .lo_data ({DW{1'b0}}),
        .rd_sel  (req_dsel),
        .rd_data (dr_val)
    );

    ixaddr_calc #(
        .AW(AW), .DW(DW), .OW(OW), .LO(ADDR_LO), .HI(ADDR_HI)
    ) u_calc (
        .mode     (req_mode),
        .step2    (req_step2),
        .ix_val   (ix_val),
        .dr_val   (dr_val),
        .ofs      (req_ofs),
        .ea       (ea_nxt),
        .wb_en    (wb_en),
        .wb_val   (wb_val),
        .in_range (in_range)
    );

    // Output stage: address and mutually exclusive outcome flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_addr    <= '0;
            ea_valid   <= 1'b0;
            ea_illegal <= 1'b0;
        end else begin
            if (req_valid)
                ea_addr <= ea_nxt;
            ea_valid   <= req_valid && in_range;
            ea_illegal <= req_valid && !in_range;
        end
    end
endmodule

// File: rtl/ixaddr_chk.sv
// Port-level property checker for ixaddr_gen, attached through bind.
// Assumes the bounds parameters match those of the bound instance.
module ixaddr_chk #(
    parameter int            AW = 32,
    parameter logic [AW-1:0] LO = 'h10,
    parameter logic [AW-1:0] HI = 'hFFFF
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] ea_addr,
    input logic          ea_valid,
    input logic          ea_illegal
);
    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ea_valid && ea_illegal));

    assert_valid_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |-> (ea_addr >= LO && ea_addr <= HI));

    assert_illegal_out_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ea_illegal |-> !(ea_addr >= LO && ea_addr <= HI));

    assert_result_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (ea_valid || ea_illegal));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!ea_valid && !ea_illegal));
endmodule

bind ixaddr_gen ixaddr_chk #(.AW(AW), .LO(ADDR_LO), .HI(ADDR_HI)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .ea_addr    (ea_addr),
    .ea_valid   (ea_valid),
    .ea_illegal (ea_illegal)
);

// File: tb/ixaddr_gen_bench.sv
// Self-checking bench: directed corners then seeded random traffic,
// compared against a register model kept in the bench.
module ixaddr_gen_bench;
    localparam logic [31:0] LO = 32'h10;
    localparam logic [31:0] HI = 32'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [3:0]  req_idx = '0;
    logic [3:0]  req_dsel = '0;
    logic [11:0] req_ofs = '0;
    logic        req_step2 = 1'b0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [31:0] ld_addr = '0;
    logic        dw_en = 1'b0;
    logic [3:0]  dw_sel = '0;
    logic [15:0] dw_data = '0;
    logic [31:0] ea_addr;
    logic        ea_valid;
    logic        ea_illegal;

    logic [31:0] m_ix [16];
    logic [15:0] m_dr [16];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ixaddr_gen u_ixaddr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_idx(req_idx), .req_dsel(req_dsel), .req_ofs(req_ofs),
        .req_step2(req_step2), .ld_en(ld_en), .ld_idx(ld_idx), .ld_addr(ld_addr),
        .dw_en(dw_en), .dw_sel(dw_sel), .dw_data(dw_data),
        .ea_addr(ea_addr), .ea_valid(ea_valid), .ea_illegal(ea_illegal)
    );

    function automatic logic [31:0] exp_ea(input logic [2:0] md, input logic [31:0] ix,
                                           input logic [15:0] dr, input logic [11:0] of,
                                           input logic s2);
        logic [31:0] st = s2 ? 32'd2 : 32'd1;
        case (md)
            3'd1:    return ix + {{20{of[11]}}, of};
            3'd2:    return ix + {{16{dr[15]}}, dr};
            3'd4:    return ix - st;
            default: return ix;
        endcase
    endfunction

    function automatic string mode_req(input logic [2:0] md);
        case (md)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // One cycle of stimulus; checks the outputs one edge later.
    task automatic cyc(input string rq, input logic rv, input logic [2:0] md,
                       input logic [3:0] ix, input logic [3:0] ds, input logic [11:0] of,
                       input logic s2, input logic le, input logic [3:0] li,
                       input logic [31:0] la, input logic de, input logic [3:0] dsl,
                       input logic [15:0] dd);
        logic [31:0] e;
        logic ok;
        e  = exp_ea(md, m_ix[ix], m_dr[ds], of, s2);
        ok = (e >= LO) && (e <= HI);
        req_valid = rv; req_mode = md; req_idx = ix; req_dsel = ds;
        req_ofs = of; req_step2 = s2; ld_en = le; ld_idx = li; ld_addr = la;
        dw_en = de; dw_sel = dsl; dw_data = dd;
        @(negedge clk);
        if (rv) begin
            check(rq, ea_addr, e);
            check("R8 valid", {31'd0, ea_valid}, {31'd0, ok});
            check("R8 illegal", {31'd0, ea_illegal}, {31'd0, !ok});
            if (md == 3'd3) m_ix[ix] = m_ix[ix] + (s2 ? 32'd2 : 32'd1);
            if (md == 3'd4) m_ix[ix] = e;
        end else begin
            check("R9 idle strobes", {30'd0, ea_valid, ea_illegal}, 32'd0);
        end
        if (le) m_ix[li] = la;
        if (de) m_dr[dsl] = dd;
        req_valid = 1'b0; ld_en = 1'b0; dw_en = 1'b0;
    endtask

    task automatic rq(input string r, input logic [2:0] md, input logic [3:0] ix,
                      input logic [11:0] of, input logic s2);
        cyc(r, 1'b1, md, ix, 4'd0, of, s2, 1'b0, 4'd0, 32'd0, 1'b0, 4'd0, 16'd0);
    endtask

    task automatic load(input logic [3:0] ix, input logic [31:0] a);
        cyc("R7", 1'b0, 3'd0, 4'd0, 4'd0, 12'd0, 1'b0, 1'b1, ix, a, 1'b0, 4'd0, 16'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_ix[i] = '0; m_dr[i] = '0; end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: outputs cleared by reset
        check("R1 addr", ea_addr, 32'd0);
        check("R1 strobes", {30'd0, ea_valid, ea_illegal}, 32'd0);
        rst_n = 1'b1;
        rq("R1 cleared pointer", 3'd0, 4'd5, 12'd0, 1'b0);
        // R7 load then R2 plain read
        load(4'd0, 32'h100);
        rq("R2 R7 plain after load", 3'd0, 4'd0, 12'd0, 1'b0);
        // R3 immediate offsets, pointer untouched
        rq("R3 +5", 3'd1, 4'd0, 12'h005, 1'b0);
        rq("R3 -2048 wrap R10", 3'd1, 4'd0, 12'h800, 1'b0);
        rq("R3 +2047", 3'd1, 4'd0, 12'h7FF, 1'b0);
        rq("R3 pointer unchanged", 3'd0, 4'd0, 12'd0, 1'b0);
        // R4 data register offset, write in same cycle not seen
        cyc("R4", 1'b0, 3'd0, 4'd0, 4'd0, 12'd0, 1'b0, 1'b0, 4'd0, 32'd0, 1'b1, 4'd3, 16'hFFF0);
        cyc("R4 negative offset", 1'b1, 3'd2, 4'd0, 4'd3, 12'd0, 1'b0, 1'b0, 4'd0, 32'd0, 1'b1, 4'd3, 16'h0040);
        cyc("R4 new data", 1'b1, 3'd2, 4'd0, 4'd3, 12'd0, 1'b0, 1'b0, 4'd0, 32'd0, 1'b0, 4'd0, 16'd0);
        rq("R4 pointer unchanged", 3'd0, 4'd0, 12'd0, 1'b0);
        // R5/R6/R9 back-to-back stepping
        rq("R5 R9 post by 1", 3'd3, 4'd0, 12'd0, 1'b0);
        rq("R5 R9 post by 2", 3'd3, 4'd0, 12'd0, 1'b1);
        rq("R5 R9 after post", 3'd0, 4'd0, 12'd0, 1'b0);
        rq("R6 pre by 2", 3'd4, 4'd0, 12'd0, 1'b1);
        rq("R6 pre by 1", 3'd4, 4'd0, 12'd0, 1'b0);
        rq("R6 after pre", 3'd0, 4'd0, 12'd0, 1'b0);
        // R8 inclusive bounds, write-back on illegal access
        load(4'd1, 32'hFFFF);
        rq("R8 upper edge post", 3'd3, 4'd1, 12'd0, 1'b0);
        rq("R8 past upper", 3'd0, 4'd1, 12'd0, 1'b0);
        load(4'd2, 32'h10);
        rq("R8 lower edge", 3'd0, 4'd2, 12'd0, 1'b0);
        rq("R8 pre below lower", 3'd4, 4'd2, 12'd0, 1'b0);
        rq("R8 write-back kept", 3'd0, 4'd2, 12'd0, 1'b0);
        // R7 load beats write-back on the same pointer
        load(4'd4, 32'h200);
        cyc("R7 collide", 1'b1, 3'd3, 4'd4, 4'd0, 12'd0, 1'b0, 1'b1, 4'd4, 32'h500, 1'b0, 4'd0, 16'd0);
        rq("R7 load wins", 3'd0, 4'd4, 12'd0, 1'b0);
        // R9 idle, R10 unused code and zero-pointer wrap
        cyc("R9", 1'b0, 3'd3, 4'd0, 4'd0, 12'd0, 1'b0, 1'b0, 4'd0, 32'd0, 1'b0, 4'd0, 16'd0);
        rq("R9 idle had no effect", 3'd0, 4'd0, 12'd0, 1'b0);
        rq("R10 code 6", 3'd6, 4'd0, 12'd0, 1'b1);
        rq("R10 code 6 no write-back", 3'd0, 4'd0, 12'd0, 1'b0);
        rq("R10 wrap below zero", 3'd4, 4'd7, 12'd0, 1'b0);
        // Seeded random traffic
        for (int n = 0; n < 600; n++) begin
            logic [2:0] md = 3'($urandom_range(0, 7));
            logic [31:0] la = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 32))
                                                         : 32'($urandom_range(0, 32'h10020));
            cyc(mode_req(md), ($urandom_range(0, 4) != 0), md, 4'($urandom),
                4'($urandom), 12'($urandom), 1'($urandom),
                ($urandom_range(0, 3) == 0), 4'($urandom), la,
                ($urandom_range(0, 2) == 0), 4'($urandom), 16'($urandom));
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule